// File: doc/BRIEF.md
# Decoded Johnson Decade Counter

This block counts events in a ring of ten states. It holds the count in a five-stage twisted-ring register and decodes it into ten outputs, exactly one of which is high. A carry line is high for the first half of the decade and low for the second half, so it forms a symmetric divide-by-ten waveform that can drive a following stage. Both count controls come from outside the clock domain. Each passes through a synchronizer before an edge detector turns the qualifying transitions into single-cycle advance strobes.

Either control can serve as the clock. A rising edge on `count_in` advances the counter while `enable_n` is low. A falling edge on `enable_n` advances it while `count_in` is high. A `modulus` input shortens the decade by forcing a synchronous return to state 0 after a chosen last state. `clear` returns the counter to state 0 asynchronously and takes priority over everything else. The control pins are plain levels with no handshake, because the block carries no data stream.

Top module: `johnson_decade_counter`

## Requirements
- R1: Each advance changes exactly one bit of the five-bit twisted-ring state. Without a shortened modulus, ten advances bring the counter back to the state it started from.
- R2: In every legal state exactly one bit of `q_out` is high. Bit k is high in state k, and the states follow the order 0, 1, …, 9, then 0 again.
- R3: `carry_out` is 1 in states 0 to 4 and 0 in states 5 to 9.
- R4: A rising edge on `count_in` while `enable_n` is low advances the counter by one state. The outputs show the new state no later than three clock edges after the input changes.
- R5: While `enable_n` is high, edges on `count_in` cause no advance and the state is held. A falling edge on `count_in` never advances the counter.
- R6: A falling edge on `enable_n` while `count_in` is high advances the counter by one state. The same falling edge while `count_in` is low does nothing, and a rising edge on `enable_n` never advances the counter.
- R7: `clear` high immediately forces `q_out` to 1 (only bit 0 high) and `carry_out` to 1, without waiting for a clock edge. Edges seen on the control inputs while `clear` is high are discarded. `clear` must be held for at least three clock cycles.
- R8: When a qualifying `count_in` rise and a qualifying `enable_n` fall are detected in the same clock cycle, the counter advances by exactly one state.
- R9: If the state register holds any pattern outside the ten legal ones, it returns to state 0 on the next clock edge.
- R10: With `modulus` between 2 and 10, an advance from state `modulus`-1 goes to state 0, and `q_out` bits above that index never go high. Any other `modulus` value behaves as 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clear | input | 1 | Asynchronous counter clear, active high |
| count_in | input | 1 | Count control, asynchronous, rising edge counts |
| enable_n | input | 1 | Active-low enable, asynchronous, falling edge also counts |
| modulus | input | 4 | Number of states in the cycle (2 to 10, other values mean 10) |
| q_out | output | 10 | One-hot decoded state |
| carry_out | output | 1 | High in states 0 to 4 |

## Verification
Two events can land in the same system cycle: a rising edge on the count input and a falling edge on the active-low enable. The bench provokes this by changing both inputs at the same moment, so both reach the synchronizer output together. It then expects the one-hot output to have moved by one position, not two. A second collision is a shortened-modulus wrap arriving on the same advance as the last-state decode. This case is judged by checking that the output returns to bit 0 and that no higher bit ever lights.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  // Synchronized control levels and the edges found on them
  typedef struct packed {
    logic cnt_lvl;
    logic cnt_rise;
    logic en_n_lvl;
    logic en_fall;
  } ctl_evt_t;
endpackage

// File: rtl/jdc_edge_sync.sv
module jdc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              cnt_async,
  input  logic              en_n_async,
  output jdc_pkg::ctl_evt_t evt
);
  logic [SYNC_STAGES-1:0] cnt_pipe;
  logic [SYNC_STAGES-1:0] en_pipe;
  logic                   cnt_prev;
  logic                   en_prev;

  // Reset-free synchronizer chains; the clear window flushes them
  always_ff @(posedge clk) begin
    cnt_pipe <= {cnt_pipe[SYNC_STAGES-2:0], cnt_async};
    en_pipe  <= {en_pipe[SYNC_STAGES-2:0], en_n_async};
    cnt_prev <= cnt_pipe[SYNC_STAGES-1];
    en_prev  <= en_pipe[SYNC_STAGES-1];
  end

  always_comb begin
    evt.cnt_lvl  = cnt_pipe[SYNC_STAGES-1];
    evt.en_n_lvl = en_pipe[SYNC_STAGES-1];
    evt.cnt_rise = cnt_pipe[SYNC_STAGES-1] & ~cnt_prev;
    evt.en_fall  = ~en_pipe[SYNC_STAGES-1] & en_prev;
  end
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int RING_BITS = 5
) (
  input  logic                 clk,
  input  logic                 clear,
  input  logic                 advance,
  input  logic                 hit_last,
  output logic [RING_BITS-1:0] ring_q,
  output logic                 legal
);
  logic [RING_BITS-1:0] twist_next;

  // A legal twisted-ring word has at most one boundary between neighbouring bits
  always_comb begin
    legal      = ($countones(ring_q[RING_BITS-2:0] ^ ring_q[RING_BITS-1:1]) <= 1);
    twist_next = {ring_q[RING_BITS-2:0], ~ring_q[RING_BITS-1]};
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear)         ring_q <= '0;
    else if (!legal)   ring_q <= '0;
    else if (advance)  ring_q <= hit_last ? '0 : twist_next;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clear)
    (legal && !advance) |=> ($stable(ring_q) || !legal)); // R5
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (clear)
    (legal && advance && !hit_last) |=> (($countones(ring_q ^ $past(ring_q)) == 1) || !legal)); // R1
  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (clear)
    !legal |=> (ring_q == '0)); // R9
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int RING_BITS = 5,
  localparam int NUM_OUT  = 2 * RING_BITS
) (
  input  logic [RING_BITS-1:0] ring_q,
  output logic [NUM_OUT-1:0]   q_vec,
  output logic                 carry
);
  // Two-input decode per state: the ring boundary position names the state
  assign q_vec[0]         = ~ring_q[RING_BITS-1] & ~ring_q[0];
  assign q_vec[RING_BITS] =  ring_q[RING_BITS-1] &  ring_q[0];

  for (genvar i = 1; i < RING_BITS; i++) begin : g_dec
    assign q_vec[i]             =  ring_q[i-1] & ~ring_q[i];
    assign q_vec[RING_BITS + i] = ~ring_q[i-1] &  ring_q[i];
  end

  // First half of the cycle has the top stage still clear
  assign carry = ~ring_q[RING_BITS-1];
endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter #(
  parameter int  RING_BITS   = 5,
  parameter int  SYNC_STAGES = 2,
  localparam int NUM_OUT     = 2 * RING_BITS,
  localparam int MOD_W       = $clog2(NUM_OUT + 1)
) (
  input  logic               clk,
  input  logic               clear,
  input  logic               count_in,
  input  logic               enable_n,
  input  logic [MOD_W-1:0]   modulus,
  output logic [NUM_OUT-1:0] q_out,
  output logic               carry_out
);
  jdc_pkg::ctl_evt_t    evt;
  logic [RING_BITS-1:0] ring_q;
  logic                 legal;
  logic                 advance;
  logic                 hit_last;
  logic [MOD_W-1:0]     last_idx;

  jdc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .cnt_async  (count_in),
    .en_n_async (enable_n),
    .evt        (evt)
  );

  // Either control may clock; a coincident pair still yields one strobe
  assign advance = ~clear & ((evt.cnt_rise & ~evt.en_n_lvl) | (evt.en_fall & evt.cnt_lvl));

  always_comb begin
    if (modulus >= MOD_W'(2) && modulus <= MOD_W'(NUM_OUT)) last_idx = modulus - MOD_W'(1);
    else                                                      last_idx = MOD_W'(NUM_OUT - 1);
  end

  assign hit_last = q_out[last_idx];

  jdc_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk      (clk),
    .clear    (clear),
    .advance  (advance),
    .hit_last (hit_last),
    .ring_q   (ring_q),
    .legal    (legal)
  );

  jdc_decode #(.RING_BITS(RING_BITS)) u_dec (
    .ring_q (ring_q),
    .q_vec  (q_out),
    .carry  (carry_out)
  );

  AST_SINGLE_HOT: assert property (@(posedge clk) disable iff (clear)
    legal |-> ($countones(q_out) == 1)); // R2
  AST_CARRY_HALF: assert property (@(posedge clk) disable iff (clear)
    legal |-> (carry_out == (|q_out[RING_BITS-1:0]))); // R3
  AST_CLEAR_STATE: assert property (@(posedge clk)
    clear |-> (q_out == NUM_OUT'(1) && carry_out)); // R7
  AST_DUAL_EDGE_ONE_STEP: assert property (@(posedge clk) disable iff (clear)
    (advance && legal && !hit_last) |=> (q_out == ($past(q_out) << 1))); // R8
  AST_WRAP_AT_LAST: assert property (@(posedge clk) disable iff (clear)
    (advance && legal && hit_last) |=> (q_out == NUM_OUT'(1))); // R10
endmodule

// File: tb/tb_johnson_decade_counter.sv
module tb_johnson_decade_counter;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       count_in = 1'b0;
  logic       enable_n = 1'b1;
  logic [3:0] modulus = 4'd10;
  logic [9:0] q_out;
  logic       carry_out;

  johnson_decade_counter dut (
    .clk(clk), .clear(clear), .count_in(count_in), .enable_n(enable_n),
    .modulus(modulus), .q_out(q_out), .carry_out(carry_out)
  );

  always #5 clk = ~clk;

  typedef struct { int idx; string tag; } exp_t;
  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   m_idx = 0;
  logic cur_cnt = 1'b0;
  logic cur_en  = 1'b1;
  bit   done = 0;

  function automatic int last_of(input logic [3:0] m);
    return (m >= 4'd2 && m <= 4'd10) ? int'(m) - 1 : 9;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.idx = m_idx;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: applies new levels, advances the reference model, queues the expectation
  task automatic drive(input logic nc, input logic ne, input string tag);
    bit rise, fall, adv;
    rise = nc & ~cur_cnt;
    fall = ~ne & cur_en;
    adv  = (rise & ~ne) | (fall & nc);
    @(negedge clk);
    count_in = nc;
    enable_n = ne;
    cur_cnt  = nc;
    cur_en   = ne;
    if (adv) m_idx = (m_idx == last_of(modulus) || m_idx == 9) ? 0 : m_idx + 1;
    repeat (4) @(negedge clk);
    push(tag);
  endtask

  task automatic pulse(input string tag);
    drive(1'b1, cur_en, tag);
    drive(1'b0, cur_en, tag);
  endtask

  task automatic check_now(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // Monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [9:0] ev;
        e  = exp_q.pop_front();
        ev = 10'(1) << e.idx;
        check_now(q_out == ev, {e.tag, " q_out"}, q_out, ev);
        check_now(carry_out == (e.idx < 5), {e.tag, " carry_out R3"},
                  {9'd0, carry_out}, {9'd0, (e.idx < 5)});
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000ns;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    m_idx = 0;
    push("R7 reset state");
    @(negedge clk);
    clear = 1'b0;
    repeat (3) @(negedge clk);

    // R6: enable falling with count low does not advance
    drive(1'b0, 1'b0, "R6 enable fall with count low");
    // R1 R2 R3 R4: twelve count pulses wrap through the decade
    for (int i = 0; i < 12; i++) pulse("R4 count pulse R1 R2");
    // R5: enable high inhibits
    drive(1'b0, 1'b1, "R6 enable rise no advance");
    for (int i = 0; i < 3; i++) pulse("R5 inhibited pulse");
    // R6: enable as negative-edge clock, count high as enable
    drive(1'b1, 1'b1, "R5 count rise while inhibited");
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, 1'b0, "R6 enable fall clocks");
      drive(1'b1, 1'b1, "R6 enable rise holds");
    end
    drive(1'b0, 1'b1, "R5 count fall no advance");
    // R8: both qualifying edges in one cycle
    drive(1'b1, 1'b0, "R8 coincident edges one step");
    drive(1'b0, 1'b1, "R8 return idle");
    drive(1'b1, 1'b0, "R8 coincident edges again");

    // R7: asynchronous clear mid-cycle, edges during clear discarded
    @(negedge clk);
    #2 clear = 1'b1;
    #1 check_now(q_out == 10'd1 && carry_out, "R7 async clear", q_out, 10'd1);
    @(negedge clk);
    count_in = 1'b0; enable_n = 1'b1;
    @(negedge clk);
    count_in = 1'b1; enable_n = 1'b0;
    cur_cnt = 1'b1; cur_en = 1'b0;
    repeat (4) @(negedge clk);
    clear = 1'b0;
    m_idx = 0;
    repeat (4) @(negedge clk);
    push("R7 edges during clear ignored");
    drive(1'b0, 1'b0, "R7 after clear");

    // R10: shortened moduli, then an out-of-range value
    modulus = 4'd3;
    for (int i = 0; i < 7; i++) pulse("R10 modulus 3");
    @(negedge clk); clear = 1'b1; repeat (4) @(negedge clk); clear = 1'b0; m_idx = 0;
    modulus = 4'd2;
    for (int i = 0; i < 5; i++) pulse("R10 modulus 2");
    @(negedge clk); clear = 1'b1; repeat (4) @(negedge clk); clear = 1'b0; m_idx = 0;
    modulus = 4'd0;
    for (int i = 0; i < 11; i++) pulse("R10 modulus 0 acts as 10");

    // R9: inject an illegal ring pattern, expect state 0 after one edge
    repeat (3) @(negedge clk);
    force dut.u_ring.ring_q = 5'b01010;
    #1 release dut.u_ring.ring_q;
    @(negedge clk);
    m_idx = 0;
    check_now(q_out == 10'd1, "R9 illegal pattern recovery", q_out, 10'd1);
    pulse("R9 counts after recovery");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule